// File: doc/BRIEF.md
# Bus Traffic Byte Meter

This block sits beside one port of an on-chip bus and adds up the bytes that cross it. Each beat carries a byte count on `beat_bytes`, marked by `beat_valid`. While counting is switched on, the meter adds that amount to a running total. The total is compared with a programmable threshold after every beat. Crossing the threshold, or running the counter past its top value, sets a sticky flag. A flag can raise an interrupt once the port-level enable and the global enable are both on.

A build-time parameter picks the counting mode. In overflow mode the counter runs on past the threshold, wraps modulo 2^CNT_W and records the wrap in its own flag. In wrap mode the counter drops back by the threshold each time it reaches it, so the true total is the readback plus one threshold per hit. A second register window, selected by `reg_glb`, holds the global interrupt enable, status and clear. Each of these uses bit `PORT_IDX` for this port. A 5-bit pacing value is stored in the control register so that neighbouring logic can pick it up, and it survives whatever the run bit does.

Software typically clears the run bit, reads the count and the status, clears both, and then sets the run bit again. While the run bit is 0 nothing moves, so these steps cannot race with traffic.

Top module: `traffic_meter`

## Requirements
- R1: After reset every register reads 0 and `irq` is low.
- R2: Control register at offset 0x280: bit 0 is the run bit and bits 20:16 hold the pacing value. Both are written together and read back as written, whatever bit 0 holds. All other bits read 0.
- R3: While the run bit is 0, beats leave the count unchanged and set no status bit.
- R4: While the run bit is 1, each cycle with `beat_valid` high adds `beat_bytes` to the count, which reads at offset 0x288. The threshold at 0x290 is read/write and holds the low CNT_W bits of the write.
- R5: Writing a value with bit 0 set to offset 0x284 makes the count 0, and a beat in the same cycle is dropped. Writing 0 there has no effect.
- R6: Overflow mode (WRAP_AT_THRES=0): the new count is (count + bytes) mod 2^CNT_W. Status bit 0 is set when count + bytes >= threshold. Status bit 1 is set when count + bytes >= 2^CNT_W.
- R7: Wrap mode (WRAP_AT_THRES=1): when count + bytes >= threshold, the count becomes count + bytes - threshold and status bit 0 is set. Otherwise the count becomes count + bytes. Status bit 1 is never set.
- R8: Status at 0x100 is sticky. Writing a mask to 0x108 clears the status bits where the mask has a 1. If a clear and a set event fall in the same cycle, the set event wins.
- R9: Global window (`reg_glb`=1): the enable at 0x10C stores only bit PORT_IDX. The status at 0x100 sets bit PORT_IDX on any port status event. Writing 0x108 with bit PORT_IDX set clears that bit. Other bits are ignored and read 0.
- R10: `irq` is high exactly when the port enable (bit 0 at 0x10C), the global enable bit and at least one port status bit are all set.
- R11: Write-only and unmapped offsets read 0 in both windows.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| reg_wr | input | 1 | Register write strobe |
| reg_glb | input | 1 | 1 selects the global window, 0 selects the port window |
| reg_addr | input | ADDR_W | Byte offset within the selected window |
| reg_wdata | input | 32 | Write data |
| reg_rdata | output | 32 | Read data for `reg_addr`, combinational |
| beat_valid | input | 1 | A transfer beat is present |
| beat_bytes | input | BEAT_W | Bytes moved by this beat |
| irq | output | 1 | Interrupt request |

## Verification
A 10-bit counter is swept with several thresholds, from 1 up to the top count. Each threshold gets a stream of twelve beats whose sizes step across the full byte range. Overflow mode and wrap mode are fed the same stream, so the readback shows where the two modes part: a wrap-mode count falls back by the threshold, while an overflow-mode count keeps climbing and then wraps past its top. Beats with the run bit low, and counter clears that coincide with a beat, show whether the gating and the clear priority hold. Sweeping the two interrupt enables and the two clear registers one at a time shows which gate feeds the interrupt line, and that a clear only removes the bit it names.

// File: rtl/tm_pkg.sv
// Shared constants and types for the bus traffic byte meter.
// Assumes byte offsets inside each register window fit in 12 bits.
package tm_pkg;

    // Offsets shared by the port and global windows
    localparam int OFS_FLAG_STS  = 'h100;
    localparam int OFS_FLAG_CLR  = 'h108;
    localparam int OFS_FLAG_EN   = 'h10C;

    // Offsets used only by the port window
    localparam int OFS_CTRL      = 'h280;
    localparam int OFS_ZERO      = 'h284;
    localparam int OFS_COUNT     = 'h288;
    localparam int OFS_LIMIT     = 'h290;

    // Lowest bit of the pacing field in the control register
    localparam int PACE_LSB      = 16;

    // Events raised by the counter in one cycle
    typedef struct packed {
        logic ovf;
        logic hit;
    } tm_evt_t;

endpackage

// File: rtl/tm_regs.sv
// Register decode and storage for the meter.
// Holds run, pacing, threshold, port and global interrupt enables.
// Produces one-cycle strobes for counter zeroing and flag clears.
// Read data is a combinational mux of stored state.
// Assumes PORT_IDX < 32 and CNT_W <= 32.
module tm_regs #(
    parameter int ADDR_W   = 12,
    parameter int CNT_W    = 32,
    parameter int PACE_W   = 5,
    parameter int PORT_IDX = 0
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              reg_wr,
    input  logic              reg_glb,
    input  logic [ADDR_W-1:0] reg_addr,
    input  logic [31:0]       reg_wdata,
    output logic [31:0]       reg_rdata,
    input  logic [CNT_W-1:0]  cnt_val,
    input  logic [1:0]        sts,
    input  logic              glb_sts,
    output logic              run,
    output logic [CNT_W-1:0]  limit,
    output logic              port_ie,
    output logic              glb_en_bit,
    output logic              cnt_clr,
    output logic [1:0]        sts_clr,
    output logic              glb_clr
);
    import tm_pkg::*;

    localparam logic [ADDR_W-1:0] A_STS   = ADDR_W'(OFS_FLAG_STS);
    localparam logic [ADDR_W-1:0] A_CLR   = ADDR_W'(OFS_FLAG_CLR);
    localparam logic [ADDR_W-1:0] A_EN    = ADDR_W'(OFS_FLAG_EN);
    localparam logic [ADDR_W-1:0] A_CTRL  = ADDR_W'(OFS_CTRL);
    localparam logic [ADDR_W-1:0] A_ZERO  = ADDR_W'(OFS_ZERO);
    localparam logic [ADDR_W-1:0] A_COUNT = ADDR_W'(OFS_COUNT);
    localparam logic [ADDR_W-1:0] A_LIMIT = ADDR_W'(OFS_LIMIT);

    logic              p_wr;
    logic              g_wr;
    logic              run_q;
    logic [PACE_W-1:0] pace_q;
    logic [CNT_W-1:0]  limit_q;
    logic              ie_q;
    logic              gen_q;
    logic              wdata_unused;

    assign p_wr = reg_wr & ~reg_glb;
    assign g_wr = reg_wr &  reg_glb;
    assign wdata_unused = ^reg_wdata;

    // Control register: run bit and pacing field written together
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            run_q  <= 1'b0;
            pace_q <= '0;
        end else if (p_wr && reg_addr == A_CTRL) begin
            run_q  <= reg_wdata[0];
            pace_q <= reg_wdata[PACE_LSB +: PACE_W];
        end
    end

    // Threshold register keeps the low CNT_W bits of a write
    always_ff @(posedge clk) begin
        if (!rst_n)
            limit_q <= '0;
        else if (p_wr && reg_addr == A_LIMIT)
            limit_q <= reg_wdata[CNT_W-1:0];
    end

    // Port-level interrupt enable
    always_ff @(posedge clk) begin
        if (!rst_n)
            ie_q <= 1'b0;
        else if (p_wr && reg_addr == A_EN)
            ie_q <= reg_wdata[0];
    end

    // Global interrupt enable, only this port's bit is stored
    always_ff @(posedge clk) begin
        if (!rst_n)
            gen_q <= 1'b0;
        else if (g_wr && reg_addr == A_EN)
            gen_q <= reg_wdata[PORT_IDX];
    end

    // One-cycle strobes for zeroing and flag clears
    always_comb begin
        cnt_clr = p_wr && (reg_addr == A_ZERO) && reg_wdata[0];
        sts_clr = (p_wr && reg_addr == A_CLR) ? reg_wdata[1:0] : 2'b00;
        glb_clr = g_wr && (reg_addr == A_CLR) && reg_wdata[PORT_IDX];
    end

    // Read mux over both windows
    always_comb begin
        reg_rdata = '0;
        if (reg_glb) begin
            unique case (reg_addr)
                A_STS:   reg_rdata[PORT_IDX] = glb_sts;
                A_EN:    reg_rdata[PORT_IDX] = gen_q;
                default: reg_rdata = '0;
            endcase
        end else begin
            unique case (reg_addr)
                A_STS:   reg_rdata[1:0] = sts;
                A_EN:    reg_rdata[0]   = ie_q;
                A_CTRL: begin
                    reg_rdata[0]                 = run_q;
                    reg_rdata[PACE_LSB +: PACE_W] = pace_q;
                end
                A_COUNT: reg_rdata = 32'(cnt_val);
                A_LIMIT: reg_rdata = 32'(limit_q);
                default: reg_rdata = '0;
            endcase
        end
    end

    assign run        = run_q;
    assign limit      = limit_q;
    assign port_ie    = ie_q;
    assign glb_en_bit = gen_q;

endmodule

// File: rtl/tm_count.sv
// Byte counter with threshold compare.
// Adds the beat's byte count while running and raises hit/overflow
// events for the flag logic. WRAP_AT_THRES picks the counting variant.
// Assumes BEAT_W <= CNT_W. A zeroing strobe beats a same-cycle beat.
module tm_count #(
    parameter int CNT_W         = 32,
    parameter int BEAT_W        = 16,
    parameter bit WRAP_AT_THRES = 1'b0
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              run,
    input  logic              cnt_clr,
    input  logic              beat_valid,
    input  logic [BEAT_W-1:0] beat_bytes,
    input  logic [CNT_W-1:0]  limit,
    output logic [CNT_W-1:0]  cnt_val,
    output tm_pkg::tm_evt_t   evt
);
    localparam int SUM_W = CNT_W + 1;

    logic [CNT_W-1:0] cnt_q;
    logic [CNT_W-1:0] cnt_nxt;
    logic [SUM_W-1:0] sum;
    logic             take;
    logic             reach;

    // Beat is accepted only while running and not being zeroed
    assign take  = run & beat_valid & ~cnt_clr;
    assign sum   = {1'b0, cnt_q} + SUM_W'(beat_bytes);
    assign reach = (sum >= {1'b0, limit});

    generate
        if (WRAP_AT_THRES) begin : g_wrap
            logic [SUM_W-1:0] rem;
            assign rem = sum - {1'b0, limit};
            // Drop back by the threshold on reaching it, never overflow
            always_comb begin
                cnt_nxt = reach ? rem[CNT_W-1:0] : sum[CNT_W-1:0];
                evt.hit = take & reach;
                evt.ovf = 1'b0;
            end
        end else begin : g_run_on
            // Keep counting, flag wrap past the top count
            always_comb begin
                cnt_nxt = sum[CNT_W-1:0];
                evt.hit = take & reach;
                evt.ovf = take & sum[CNT_W];
            end
        end
    endgenerate

    // Counter register
    always_ff @(posedge clk) begin
        if (!rst_n)
            cnt_q <= '0;
        else if (cnt_clr)
            cnt_q <= '0;
        else if (take)
            cnt_q <= cnt_nxt;
    end

    assign cnt_val = cnt_q;

endmodule

// File: rtl/tm_flags.sv
// Sticky port flags, sticky global flag and interrupt gating.
// Set events win over a clear in the same cycle.
// Assumes clear strobes last one cycle.
module tm_flags (
    input  logic            clk,
    input  logic            rst_n,
    input  tm_pkg::tm_evt_t evt,
    input  logic [1:0]      sts_clr,
    input  logic            glb_clr,
    input  logic            port_ie,
    input  logic            glb_en_bit,
    output logic [1:0]      sts,
    output logic            glb_sts,
    output logic            irq
);
    logic [1:0] sts_q;
    logic       glb_q;
    logic       any_evt;

    assign any_evt = evt.hit | evt.ovf;

    // Port flags: clear by mask, then OR in new events
    always_ff @(posedge clk) begin
        if (!rst_n)
            sts_q <= 2'b00;
        else
            sts_q <= (sts_q & ~sts_clr) | {evt.ovf, evt.hit};
    end

    // Global flag for this port
    always_ff @(posedge clk) begin
        if (!rst_n)
            glb_q <= 1'b0;
        else
            glb_q <= (glb_q & ~glb_clr) | any_evt;
    end

    // Interrupt needs both enables and a pending port flag
    assign irq     = port_ie & glb_en_bit & (|sts_q);
    assign sts     = sts_q;
    assign glb_sts = glb_q;

endmodule

// File: rtl/traffic_meter.sv
// Top of the bus traffic byte meter: register block, counter and flags.
// Assumes a single clock domain and CNT_W <= 32.
module traffic_meter #(
    parameter int ADDR_W        = 12,
    parameter int CNT_W         = 32,
    parameter int BEAT_W        = 16,
    parameter int PACE_W        = 5,
    parameter int PORT_IDX      = 0,
    parameter bit WRAP_AT_THRES = 1'b0
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              reg_wr,
    input  logic              reg_glb,
    input  logic [ADDR_W-1:0] reg_addr,
    input  logic [31:0]       reg_wdata,
    output logic [31:0]       reg_rdata,
    input  logic              beat_valid,
    input  logic [BEAT_W-1:0] beat_bytes,
    output logic              irq
);
    logic             run;
    logic [CNT_W-1:0] limit;
    logic             port_ie;
    logic             glb_en_bit;
    logic             cnt_clr;
    logic [1:0]       sts_clr;
    logic             glb_clr;
    logic [CNT_W-1:0] cnt_val;
    logic [1:0]       sts;
    logic             glb_sts;
    tm_pkg::tm_evt_t  evt;

    tm_regs #(
        .ADDR_W   (ADDR_W),
        .CNT_W    (CNT_W),
        .PACE_W   (PACE_W),
        .PORT_IDX (PORT_IDX)
    ) u_regs (
        .clk        (clk),
        .rst_n      (rst_n),
        .reg_wr     (reg_wr),
        .reg_glb    (reg_glb),
        .reg_addr   (reg_addr),
        .reg_wdata  (reg_wdata),
        .reg_rdata  (reg_rdata),
        .cnt_val    (cnt_val),
        .sts        (sts),
        .glb_sts    (glb_sts),
        .run        (run),
        .limit      (limit),
        .port_ie    (port_ie),
        .glb_en_bit (glb_en_bit),
        .cnt_clr    (cnt_clr),
        .sts_clr    (sts_clr),
        .glb_clr    (glb_clr)
    );

    tm_count #(
        .CNT_W         (CNT_W),
        .BEAT_W        (BEAT_W),
        .WRAP_AT_THRES (WRAP_AT_THRES)
    ) u_count (
        .clk        (clk),
        .rst_n      (rst_n),
        .run        (run),
        .cnt_clr    (cnt_clr),
        .beat_valid (beat_valid),
        .beat_bytes (beat_bytes),
        .limit      (limit),
        .cnt_val    (cnt_val),
        .evt        (evt)
    );

    tm_flags u_flags (
        .clk        (clk),
        .rst_n      (rst_n),
        .evt        (evt),
        .sts_clr    (sts_clr),
        .glb_clr    (glb_clr),
        .port_ie    (port_ie),
        .glb_en_bit (glb_en_bit),
        .sts        (sts),
        .glb_sts    (glb_sts),
        .irq        (irq)
    );

endmodule

// File: rtl/traffic_meter_chk.sv
// Temporal checks on the meter, bound into every instance of the top.
module traffic_meter_chk #(
    parameter int CNT_W         = 32,
    parameter bit WRAP_AT_THRES = 1'b0
) (
    input logic             clk,
    input logic             rst_n,
    input logic             run,
    input logic             cnt_clr,
    input logic [CNT_W-1:0] cnt_val,
    input logic [1:0]       sts,
    input logic [1:0]       sts_clr,
    input logic             port_ie,
    input logic             glb_en_bit,
    input logic             irq
);
    // R3
    idle_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!run && !cnt_clr) |=> $stable(cnt_val));

    // R3
    idle_no_flag_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !run |=> ((sts & ~$past(sts)) == 2'b00));

    // R5
    zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
        cnt_clr |=> (cnt_val == '0));

    // R8
    sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (sts_clr == 2'b00) |=> ((sts & $past(sts)) == $past(sts)));

    // R10
    irq_src_chk: assert property (@(posedge clk) disable iff (!rst_n)
        irq |-> (sts != 2'b00));

    // R10
    irq_gate_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(irq) |-> (port_ie && glb_en_bit));

    generate
        if (WRAP_AT_THRES) begin : g_wrap_chk
            // R7
            no_overflow_chk: assert property (@(posedge clk) disable iff (!rst_n)
                !sts[1]);
        end else begin : g_run_on_chk
            // R6
            drop_needs_ovf_chk: assert property (@(posedge clk) disable iff (!rst_n)
                (run && !cnt_clr) |=> ((cnt_val >= $past(cnt_val)) || sts[1]));
        end
    endgenerate

endmodule

bind traffic_meter traffic_meter_chk #(
    .CNT_W         (CNT_W),
    .WRAP_AT_THRES (WRAP_AT_THRES)
) u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .run        (run),
    .cnt_clr    (cnt_clr),
    .cnt_val    (cnt_val),
    .sts        (sts),
    .sts_clr    (sts_clr),
    .port_ie    (port_ie),
    .glb_en_bit (glb_en_bit),
    .irq        (irq)
);

// File: tb/traffic_meter_bench.sv
// Bench: two meters (overflow mode and wrap mode) share every input.
module traffic_meter_bench;
    localparam int CW   = 10;
    localparam int BW   = 8;
    localparam int AW   = 12;
    localparam int PIDX = 2;
    localparam int TOP  = 1 << CW;

    localparam logic [AW-1:0] STS   = 12'h100;
    localparam logic [AW-1:0] ICLR  = 12'h108;
    localparam logic [AW-1:0] IEN   = 12'h10C;
    localparam logic [AW-1:0] CTRL  = 12'h280;
    localparam logic [AW-1:0] ZERO  = 12'h284;
    localparam logic [AW-1:0] COUNT = 12'h288;
    localparam logic [AW-1:0] LIMIT = 12'h290;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          reg_wr = 1'b0;
    logic          reg_glb = 1'b0;
    logic [AW-1:0] reg_addr = '0;
    logic [31:0]   reg_wdata = '0;
    logic          beat_valid = 1'b0;
    logic [BW-1:0] beat_bytes = '0;
    logic [31:0]   rdata_a, rdata_b;
    logic          irq_a, irq_b;
    logic [31:0]   rd_a, rd_b;

    int tests = 0;
    int fails = 0;
    int mc [2];
    logic [1:0] ms [2];

    always #5 clk = ~clk;

    traffic_meter #(.ADDR_W(AW), .CNT_W(CW), .BEAT_W(BW), .PORT_IDX(PIDX),
                    .WRAP_AT_THRES(1'b0)) u_traffic_meter (
        .clk(clk), .rst_n(rst_n), .reg_wr(reg_wr), .reg_glb(reg_glb),
        .reg_addr(reg_addr), .reg_wdata(reg_wdata), .reg_rdata(rdata_a),
        .beat_valid(beat_valid), .beat_bytes(beat_bytes), .irq(irq_a));

    traffic_meter #(.ADDR_W(AW), .CNT_W(CW), .BEAT_W(BW), .PORT_IDX(PIDX),
                    .WRAP_AT_THRES(1'b1)) u_traffic_meter_wrap (
        .clk(clk), .rst_n(rst_n), .reg_wr(reg_wr), .reg_glb(reg_glb),
        .reg_addr(reg_addr), .reg_wdata(reg_wdata), .reg_rdata(rdata_b),
        .beat_valid(beat_valid), .beat_bytes(beat_bytes), .irq(irq_b));

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        tests++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s: actual %h expected %h", tag, act, exp);
        end
    endtask

    task automatic wr(input logic g, input logic [AW-1:0] a, input logic [31:0] d);
        @(negedge clk);
        reg_wr = 1'b1; reg_glb = g; reg_addr = a; reg_wdata = d;
        @(posedge clk); #1;
        reg_wr = 1'b0;
    endtask

    task automatic beat(input logic [BW-1:0] b);
        @(negedge clk);
        beat_valid = 1'b1; beat_bytes = b;
        @(posedge clk); #1;
        beat_valid = 1'b0;
    endtask

    task automatic wr_beat(input logic [AW-1:0] a, input logic [31:0] d, input logic [BW-1:0] b);
        @(negedge clk);
        reg_wr = 1'b1; reg_glb = 1'b0; reg_addr = a; reg_wdata = d;
        beat_valid = 1'b1; beat_bytes = b;
        @(posedge clk); #1;
        reg_wr = 1'b0; beat_valid = 1'b0;
    endtask

    task automatic rd(input logic g, input logic [AW-1:0] a);
        @(negedge clk);
        reg_glb = g; reg_addr = a;
        #1;
        rd_a = rdata_a; rd_b = rdata_b;
    endtask

    task automatic rd_both(input string tag, input logic g, input logic [AW-1:0] a,
                           input logic [31:0] ea, input logic [31:0] eb);
        rd(g, a);
        chk(tag, rd_a, ea);
        chk(tag, rd_b, eb);
    endtask

    // Watchdog: a hung run counts as one failed check
    initial begin
        repeat (100000) @(posedge clk);
        fails++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("  [TB] %0d tests run, %0d failed", tests + 1, fails);
        $finish;
    end

    initial begin
        int thr_list [6] = '{1, 5, 100, 255, 600, 1023};
        repeat (4) @(posedge clk);
        @(negedge clk);
        rst_n = 1'b1;

        // R1: reset state of both windows
        rd_both("R1 count", 1'b0, COUNT, 0, 0);
        rd_both("R1 status", 1'b0, STS, 0, 0);
        rd_both("R1 ctrl", 1'b0, CTRL, 0, 0);
        rd_both("R1 limit", 1'b0, LIMIT, 0, 0);
        rd_both("R1 ie", 1'b0, IEN, 0, 0);
        rd_both("R1 glb sts", 1'b1, STS, 0, 0);
        rd_both("R1 glb en", 1'b1, IEN, 0, 0);
        chk("R1 irq", {irq_a, irq_b}, 0);

        // R2: pacing field kept with run bit low, other bits dropped
        wr(1'b0, CTRL, 32'hFFFF_FFFE);
        rd_both("R2 ctrl", 1'b0, CTRL, 32'h001F_0000, 32'h001F_0000);
        // R3: beat while stopped
        beat(8'd50);
        rd_both("R3 count idle", 1'b0, COUNT, 0, 0);
        rd_both("R3 status idle", 1'b0, STS, 0, 0);

        // R4: threshold width and plain accumulation
        wr(1'b0, LIMIT, 32'hFFFF_FFFF);
        rd_both("R4 limit trunc", 1'b0, LIMIT, 32'h3FF, 32'h3FF);
        wr(1'b0, LIMIT, 32'd1000);
        rd_both("R4 limit", 1'b0, LIMIT, 1000, 1000);
        wr(1'b0, CTRL, 32'h000A_0001);
        rd_both("R2 ctrl run", 1'b0, CTRL, 32'h000A_0001, 32'h000A_0001);
        beat(8'd50);
        rd_both("R4 count", 1'b0, COUNT, 50, 50);

        // R3: stopping again freezes count and flags
        wr(1'b0, CTRL, 32'h000A_0000);
        beat(8'd20);
        rd_both("R3 count hold", 1'b0, COUNT, 50, 50);
        rd_both("R3 status hold", 1'b0, STS, 0, 0);
        rd_both("R2 pace kept", 1'b0, CTRL, 32'h000A_0000, 32'h000A_0000);

        // R5: zeroing, priority over a beat, and a zero write
        wr(1'b0, CTRL, 32'h000A_0001);
        wr(1'b0, ZERO, 32'd1);
        rd_both("R5 zero", 1'b0, COUNT, 0, 0);
        beat(8'd40);
        rd_both("R4 count 40", 1'b0, COUNT, 40, 40);
        wr_beat(ZERO, 32'd1, 8'd30);
        rd_both("R5 zero beats beat", 1'b0, COUNT, 0, 0);
        beat(8'd10);
        wr(1'b0, ZERO, 32'd0);
        rd_both("R5 zero write ignored", 1'b0, COUNT, 10, 10);

        // R6 R7: sweep thresholds against a beat-size ramp, both modes
        for (int t = 0; t < 6; t++) begin
            wr(1'b0, ZERO, 32'd1);
            wr(1'b0, ICLR, 32'd3);
            wr(1'b0, LIMIT, 32'(thr_list[t]));
            mc[0] = 0; mc[1] = 0; ms[0] = 2'b00; ms[1] = 2'b00;
            for (int k = 0; k < 12; k++) begin
                int b;
                int s;
                b = (k * 37 + thr_list[t]) % 256;
                beat(b[BW-1:0]);
                s = mc[0] + b;
                if (s >= thr_list[t]) ms[0][0] = 1'b1;
                if (s >= TOP) ms[0][1] = 1'b1;
                mc[0] = s % TOP;
                s = mc[1] + b;
                if (s >= thr_list[t]) begin
                    ms[1][0] = 1'b1;
                    mc[1] = (s - thr_list[t]) % TOP;
                end else begin
                    mc[1] = s;
                end
                rd(1'b0, COUNT);
                chk("R6 count", rd_a, 32'(mc[0]));
                chk("R7 count", rd_b, 32'(mc[1]));
                rd(1'b0, STS);
                chk("R6 status", rd_a, 32'(ms[0]));
                chk("R7 status", rd_b, 32'(ms[1]));
            end
        end

        // R8: sticky flags, masked clear, set beats clear
        wr(1'b0, ZERO, 32'd1);
        wr(1'b0, ICLR, 32'd3);
        wr(1'b0, LIMIT, 32'd10);
        beat(8'd20);
        rd_both("R8 hit set", 1'b0, STS, 1, 1);
        rd_both("R7 residue", 1'b0, COUNT, 20, 10);
        wr(1'b0, ICLR, 32'd2);
        rd_both("R8 mask keeps", 1'b0, STS, 1, 1);
        wr(1'b0, ICLR, 32'd1);
        rd_both("R8 mask clears", 1'b0, STS, 0, 0);
        wr_beat(ICLR, 32'd3, 8'd5);
        rd_both("R8 set wins", 1'b0, STS, 1, 1);

        // R9 R10: global window and interrupt gating
        wr(1'b0, ICLR, 32'd3);
        wr(1'b1, ICLR, 32'hFFFF_FFFF);
        rd_both("R9 glb cleared", 1'b1, STS, 0, 0);
        beat(8'd5);
        rd_both("R9 glb set", 1'b1, STS, 32'h4, 32'h4);
        chk("R10 irq no enables", {irq_a, irq_b}, 2'b00);
        wr(1'b0, IEN, 32'd1);
        chk("R10 irq port only", {irq_a, irq_b}, 2'b00);
        wr(1'b1, IEN, 32'hFFFF_FFFF);
        rd_both("R9 glb en bit", 1'b1, IEN, 32'h4, 32'h4);
        chk("R10 irq both", {irq_a, irq_b}, 2'b11);
        wr(1'b1, ICLR, 32'h3);
        rd_both("R9 glb other bits", 1'b1, STS, 32'h4, 32'h4);
        wr(1'b1, ICLR, 32'h4);
        rd_both("R9 glb clear", 1'b1, STS, 0, 0);
        chk("R10 irq from port flag", {irq_a, irq_b}, 2'b11);
        wr(1'b0, IEN, 32'd0);
        chk("R10 irq port off", {irq_a, irq_b}, 2'b00);
        wr(1'b0, IEN, 32'd1);
        chk("R10 irq port on", {irq_a, irq_b}, 2'b11);
        wr(1'b1, IEN, 32'd0);
        chk("R10 irq glb off", {irq_a, irq_b}, 2'b00);
        wr(1'b1, IEN, 32'h4);
        wr(1'b0, ICLR, 32'd3);
        chk("R10 irq flags gone", {irq_a, irq_b}, 2'b00);

        // R11: write-only and unmapped offsets
        rd_both("R11 port clr", 1'b0, ICLR, 0, 0);
        rd_both("R11 zero reg", 1'b0, ZERO, 0, 0);
        rd_both("R11 unmapped", 1'b0, 12'h000, 0, 0);
        rd_both("R11 glb count", 1'b1, COUNT, 0, 0);
        rd_both("R11 glb clr", 1'b1, ICLR, 0, 0);

        $display("  [TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end

endmodule